// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Split Entry Words

This block is a fully associative translation buffer whose 64 entries are loaded and inspected by software. Software never sees a hardware refill. It writes each entry as two 32-bit words through a single-cycle operation port. The high word carries the virtual page, the page size and the valid flag. The low word carries the physical page, the access rights and eight attribute bits. The same port reads either word back one cycle later.

A process-ID register sits beside the entry array. Writing a high word tags the entry with the current register value. Reading a high word has a side effect: it loads the register with the tag of the entry read. Pages come in eight sizes, 1 KiB times a power of four.

A separate lookup port takes an address and a process ID. One cycle later it reports hit or miss, the winning index and the matched entry's translation fields. Tag 0 marks an entry as global.

Top module: `swtlb_top`

## Requirements
- R1: Only the low 6 bits of `op_index` select the entry; index 0xC3 addresses the same entry as 0x03.
- R2: A high-word write takes the size code from bits 9:7 and the valid flag from bit 6. The page size is 1024 << (2*code) bytes, and the stored page is the written word with all bits below the page size cleared. Bit 5 (byte-order flag) and bits 4:0 are not stored.
- R3: A high-word write tags the entry with the process-ID register value held before that cycle, even when `pid_wr_en` is asserted in the same cycle.
- R4: A low-word write stores the physical page from bits 31:10, execute from bit 9, write from bit 8 and attributes from bits 7:0, and always grants read. A low-word read returns {page, execute at bit 9, write at bit 8} with bits 7:0 zero.
- R5: A high-word read returns {stored page, size code at bits 9:7, valid at bit 6} with bits 5:0 zero. Any read presents `rd_data` with `rd_valid` high on the cycle after the request.
- R6: A high-word read loads the process-ID register with the entry's tag one cycle later, and takes precedence over a `pid_wr_en` in the same cycle. Otherwise `pid_wr_en` loads `pid_wr_data`.
- R7: After reset every entry is invalid, with page, tag, translation fields and rights zero and size code 1. The process-ID register is 0, and `rd_valid` and `srch_done` are low.
- R8: An entry hits when it is valid, its tag equals `srch_pid` or is 0, and `srch_addr` equals the stored page in every bit at or above the page size.
- R9: When several entries hit, the lowest index is reported.
- R10: A lookup answers on the cycle after `srch_req`, with `srch_done` high. On a hit, `srch_index`, `srch_rpn`, `srch_size`, `srch_attr` and `srch_perm` ({read, write, execute} at bits 2:0) describe the winner. On a miss, `srch_hit` and all those fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Entry operation strobe |
| op_kind | input | 2 | 0 write high, 1 write low, 2 read high, 3 read low |
| op_index | input | 8 | Entry index, low 6 bits used |
| op_wdata | input | 32 | Word to write |
| rd_data | output | 32 | Word read |
| rd_valid | output | 1 | `rd_data` is valid |
| pid_wr_en | input | 1 | Load the process-ID register |
| pid_wr_data | input | 8 | Value to load |
| pid_q | output | 8 | Current process-ID register |
| srch_req | input | 1 | Lookup request |
| srch_addr | input | 32 | Address to translate |
| srch_pid | input | 8 | Process ID for the lookup |
| srch_done | output | 1 | Lookup result valid |
| srch_hit | output | 1 | An entry matched |
| srch_index | output | 6 | Winning entry |
| srch_rpn | output | 22 | Winning physical page |
| srch_size | output | 3 | Winning size code |
| srch_attr | output | 8 | Winning attributes |
| srch_perm | output | 3 | Winning {read, write, execute} |

## Verification
The assertions assume that `op_kind` only takes its four defined codes while `op_valid` is high. They also assume that a process-ID change comes only from `pid_wr_en` or a high-word read, so no other path may disturb `pid_q`. Every operation in the directed stimulus uses one of the four codes and holds each strobe for exactly one cycle. The stimulus raises `pid_wr_en` alongside a high-word read and alongside a high-word write, so both precedence rules are exercised.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
    localparam int ENTRIES  = 64;
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int IDX_IN_W = 8;
    localparam int DATA_W   = 32;
    localparam int PID_W    = 8;
    localparam int ATTR_W   = 8;
    localparam int MIN_SH   = 10;
    localparam int PAGE_W   = DATA_W - MIN_SH;
    localparam int SIZE_W   = 3;
    localparam logic [SIZE_W-1:0] SIZE_RESET = 3'd1;

    typedef enum logic [1:0] {
        OP_WR_HI = 2'd0,
        OP_WR_LO = 2'd1,
        OP_RD_HI = 2'd2,
        OP_RD_LO = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic              valid;
        logic [SIZE_W-1:0] size;
        logic [PID_W-1:0]  pid;
        logic [PAGE_W-1:0] epn;
        logic [PAGE_W-1:0] rpn;
        logic [ATTR_W-1:0] attr;
        logic              rd;
        logic              wr;
        logic              ex;
    } tlb_entry_t;

    // Byte-offset mask of a page of the given size code.
    function automatic logic [DATA_W-1:0] page_off_mask(input logic [SIZE_W-1:0] code);
        page_off_mask = (DATA_W'(1) << (MIN_SH + 2 * int'(code))) - DATA_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] pack_hi(input tlb_entry_t e);
        pack_hi = {e.epn, MIN_SH'(0)} | (DATA_W'(e.size) << 7) | (DATA_W'(e.valid) << 6);
    endfunction

    function automatic logic [DATA_W-1:0] pack_lo(input tlb_entry_t e);
        pack_lo = {e.rpn, e.ex, e.wr, 8'h00};
    endfunction
endpackage

// File: rtl/swtlb_entry.sv
module swtlb_entry
    import swtlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PID_W-1:0]     cur_pid,
    input  logic [DATA_W-1:0]    srch_addr,
    input  logic [PID_W-1:0]     srch_pid,
    output tlb_entry_t           ent,
    output logic                 hit
);
    logic [SIZE_W-1:0] new_size;
    logic [DATA_W-1:0] new_page;
    logic [DATA_W-1:0] diff;

    assign new_size = wdata[9:7];
    assign new_page = wdata & ~page_off_mask(new_size);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent      <= '0;
            ent.size <= SIZE_RESET;
        end else if (wr_hi) begin
            ent.size  <= new_size;
            ent.valid <= wdata[6];
            ent.epn   <= new_page[DATA_W-1:MIN_SH];
            ent.pid   <= cur_pid;
        end else if (wr_lo) begin
            ent.rpn  <= wdata[DATA_W-1:MIN_SH];
            ent.ex   <= wdata[9];
            ent.wr   <= wdata[8];
            ent.attr <= wdata[ATTR_W-1:0];
            ent.rd   <= 1'b1;
        end
    end

    assign diff = (srch_addr ^ {ent.epn, MIN_SH'(0)}) & ~page_off_mask(ent.size);
    assign hit  = ent.valid && ((ent.pid == srch_pid) || (ent.pid == '0)) && (diff == '0);

    // R2: stored page never carries bits below its page size
    a_r2_page_aligned: assert property (@(posedge clk) disable iff (rst)
        (({ent.epn, MIN_SH'(0)} & page_off_mask(ent.size)) == '0));
    // R3: tag comes from the register value before the write
    a_r3_tag_from_reg: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (ent.pid == $past(cur_pid)));
    // R4: a low-word write always grants read
    a_r4_read_granted: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> ent.rd);
endmodule

// File: rtl/swtlb_prio.sv
module swtlb_prio
    import swtlb_pkg::*;
(
    input  logic [ENTRIES-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
    assign any = |hits;
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
    import swtlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [1:0]           op_kind,
    input  logic [IDX_IN_W-1:0]  op_index,
    input  logic [DATA_W-1:0]    op_wdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    input  logic                 pid_wr_en,
    input  logic [PID_W-1:0]     pid_wr_data,
    output logic [PID_W-1:0]     pid_q,
    input  logic                 srch_req,
    input  logic [DATA_W-1:0]    srch_addr,
    input  logic [PID_W-1:0]     srch_pid,
    output logic                 srch_done,
    output logic                 srch_hit,
    output logic [IDX_W-1:0]     srch_index,
    output logic [PAGE_W-1:0]    srch_rpn,
    output logic [SIZE_W-1:0]    srch_size,
    output logic [ATTR_W-1:0]    srch_attr,
    output logic [2:0]           srch_perm
);
    op_kind_e           kind;
    logic [IDX_W-1:0]   idx;
    logic               do_wr_hi, do_wr_lo, do_rd_hi, do_rd_lo;
    tlb_entry_t         ents [ENTRIES];
    logic [ENTRIES-1:0] hits;
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;
    tlb_entry_t         sel, win;

    assign kind     = op_kind_e'(op_kind);
    assign idx      = IDX_W'(op_index % IDX_IN_W'(ENTRIES));
    assign do_wr_hi = op_valid && (kind == OP_WR_HI);
    assign do_wr_lo = op_valid && (kind == OP_WR_LO);
    assign do_rd_hi = op_valid && (kind == OP_RD_HI);
    assign do_rd_lo = op_valid && (kind == OP_RD_LO);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        swtlb_entry u_ent (
            .clk       (clk),
            .rst       (rst),
            .wr_hi     (do_wr_hi && (idx == IDX_W'(g))),
            .wr_lo     (do_wr_lo && (idx == IDX_W'(g))),
            .wdata     (op_wdata),
            .cur_pid   (pid_q),
            .srch_addr (srch_addr),
            .srch_pid  (srch_pid),
            .ent       (ents[g]),
            .hit       (hits[g])
        );
    end

    swtlb_prio u_prio (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    assign sel = ents[idx];
    assign win = ents[win_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            pid_q    <= '0;
        end else begin
            rd_valid <= do_rd_hi || do_rd_lo;
            if (do_rd_hi)      rd_data <= pack_hi(sel);
            else if (do_rd_lo) rd_data <= pack_lo(sel);
            if (do_rd_hi)       pid_q <= sel.pid;
            else if (pid_wr_en) pid_q <= pid_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srch_done  <= 1'b0;
            srch_hit   <= 1'b0;
            srch_index <= '0;
            srch_rpn   <= '0;
            srch_size  <= '0;
            srch_attr  <= '0;
            srch_perm  <= '0;
        end else begin
            srch_done <= srch_req;
            if (srch_req) begin
                srch_hit   <= any_hit;
                srch_index <= any_hit ? win_idx : '0;
                srch_rpn   <= any_hit ? win.rpn : '0;
                srch_size  <= any_hit ? win.size : '0;
                srch_attr  <= any_hit ? win.attr : '0;
                srch_perm  <= any_hit ? {win.rd, win.wr, win.ex} : 3'b000;
            end
        end
    end

    // R5: every read answers on the next cycle
    a_r5_read_answers: assert property (@(posedge clk) disable iff (rst)
        (do_rd_hi || do_rd_lo) |=> rd_valid);
    // R6: the process-ID register moves only through its two sources
    a_r6_pid_sources: assert property (@(posedge clk) disable iff (rst)
        !$stable(pid_q) |-> $past(pid_wr_en || do_rd_hi));
    // R10: each request gets exactly one answer, one cycle later
    a_r10_search_answers: assert property (@(posedge clk) disable iff (rst)
        srch_req |=> srch_done);
    a_r10_no_stray_answer: assert property (@(posedge clk) disable iff (rst)
        srch_done |-> $past(srch_req));
endmodule

// File: tb/tb_swtlb_top.sv
`timescale 1ns/1ps
module tb_swtlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [7:0]  op_index = 8'd0;
    logic [31:0] op_wdata = 32'd0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        pid_wr_en = 1'b0;
    logic [7:0]  pid_wr_data = 8'd0;
    logic [7:0]  pid_q;
    logic        srch_req = 1'b0;
    logic [31:0] srch_addr = 32'd0;
    logic [7:0]  srch_pid = 8'd0;
    logic        srch_done, srch_hit;
    logic [5:0]  srch_index;
    logic [21:0] srch_rpn;
    logic [2:0]  srch_size;
    logic [7:0]  srch_attr;
    logic [2:0]  srch_perm;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Expected contents, built from the requirements.
    logic [31:0] m_page [64];
    logic [2:0]  m_size [64];
    logic        m_val  [64];
    logic [7:0]  m_pid  [64];
    logic [31:0] m_rpnw [64];
    logic [7:0]  m_attr [64];
    logic        m_ex [64], m_wr [64], m_rd [64];
    logic [7:0]  m_cur_pid;

    always #2 clk = ~clk;

    swtlb_top dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_index(op_index), .op_wdata(op_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .pid_wr_en(pid_wr_en), .pid_wr_data(pid_wr_data),
        .pid_q(pid_q), .srch_req(srch_req), .srch_addr(srch_addr),
        .srch_pid(srch_pid), .srch_done(srch_done), .srch_hit(srch_hit),
        .srch_index(srch_index), .srch_rpn(srch_rpn), .srch_size(srch_size),
        .srch_attr(srch_attr), .srch_perm(srch_perm)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] off_mask(input logic [2:0] c);
        return (32'd1024 << (2 * int'(c))) - 32'd1;
    endfunction

    // One operation; returns at the falling edge after the capturing edge.
    task automatic do_op(input logic [1:0] k, input logic [7:0] ix,
                         input logic [31:0] d, input bit with_pid, input logic [7:0] pd);
        int e;
        e = int'(ix) % 64;
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_index = ix; op_wdata = d;
        pid_wr_en = with_pid; pid_wr_data = pd;
        @(negedge clk);
        op_valid = 1'b0; pid_wr_en = 1'b0;
        if (k == 2'd0) begin
            m_size[e] = d[9:7];
            m_val[e]  = d[6];
            m_page[e] = d & ~off_mask(d[9:7]);
            m_pid[e]  = m_cur_pid;
        end else if (k == 2'd1) begin
            m_rpnw[e] = d & 32'hFFFF_FC00;
            m_ex[e] = d[9]; m_wr[e] = d[8]; m_attr[e] = d[7:0]; m_rd[e] = 1'b1;
        end
        if (k == 2'd2) m_cur_pid = m_pid[e];
        else if (with_pid) m_cur_pid = pd;
    endtask

    task automatic set_pid(input logic [7:0] p);
        @(negedge clk);
        pid_wr_en = 1'b1; pid_wr_data = p;
        @(negedge clk);
        pid_wr_en = 1'b0;
        m_cur_pid = p;
    endtask

    function automatic logic [31:0] exp_hi(input int e);
        return m_page[e] | (32'(m_size[e]) << 7) | (32'(m_val[e]) << 6);
    endfunction

    function automatic logic [31:0] exp_lo(input int e);
        return m_rpnw[e] | (32'(m_ex[e]) << 9) | (32'(m_wr[e]) << 8);
    endfunction

    task automatic read_check(input string req, input logic [1:0] k, input logic [7:0] ix);
        int e;
        e = int'(ix) % 64;
        do_op(k, ix, 32'd0, 1'b0, 8'd0);
        check(req, "rd_valid", 32'(rd_valid), 32'd1);
        check(req, "rd_data", rd_data, (k == 2'd2) ? exp_hi(e) : exp_lo(e));
    endtask

    task automatic search_check(input string req, input logic [31:0] a, input logic [7:0] p);
        int w;
        w = -1;
        for (int i = 63; i >= 0; i--) begin
            if (m_val[i] && (m_pid[i] == p || m_pid[i] == 8'd0) &&
                (((a ^ m_page[i]) & ~off_mask(m_size[i])) == 32'd0)) w = i;
        end
        @(negedge clk);
        srch_req = 1'b1; srch_addr = a; srch_pid = p;
        @(negedge clk);
        srch_req = 1'b0;
        check(req, "srch_done", 32'(srch_done), 32'd1);
        check(req, "srch_hit", 32'(srch_hit), (w >= 0) ? 32'd1 : 32'd0);
        if (w >= 0) begin
            check(req, "srch_index", 32'(srch_index), 32'(w));
            check(req, "srch_rpn", 32'(srch_rpn), m_rpnw[w] >> 10);
            check(req, "srch_size", 32'(srch_size), 32'(m_size[w]));
            check(req, "srch_attr", 32'(srch_attr), 32'(m_attr[w]));
            check(req, "srch_perm", 32'(srch_perm), 32'({m_rd[w], m_wr[w], m_ex[w]}));
        end else begin
            check(req, "miss fields", 32'({srch_index, srch_attr, srch_perm, srch_size}), 32'd0);
        end
    endtask

    task automatic t_reset;
        // R7
        check("R7", "rd_valid", 32'(rd_valid), 32'd0);
        check("R7", "srch_done", 32'(srch_done), 32'd0);
        check("R7", "pid_q", 32'(pid_q), 32'd0);
        read_check("R7", 2'd2, 8'd5);
        read_check("R7", 2'd3, 8'd5);
        search_check("R7", 32'h0000_0000, 8'd0);
    endtask

    task automatic t_hi_words;
        // R2, R3, R5
        set_pid(8'h12);
        do_op(2'd0, 8'd3, 32'h1234_5E60, 1'b0, 8'd0);
        read_check("R5", 2'd2, 8'd3);
        check("R2", "page cleared", rd_data, 32'h1234_0240);
        do_op(2'd0, 8'd4, 32'hFFFF_FFFF, 1'b1, 8'h77);
        read_check("R2", 2'd2, 8'd4);
        check("R3", "old tag used", 32'(pid_q), 32'h12);
        do_op(2'd0, 8'd6, 32'h0001_2C7F, 1'b0, 8'd0);
        read_check("R2", 2'd2, 8'd6);
    endtask

    task automatic t_lo_words;
        // R4
        do_op(2'd1, 8'd3, 32'hABCD_E3FF, 1'b0, 8'd0);
        read_check("R4", 2'd3, 8'd3);
        check("R4", "lo literal", rd_data, 32'hABCD_E300);
        do_op(2'd1, 8'd4, 32'h0000_0412, 1'b0, 8'd0);
        read_check("R4", 2'd3, 8'd4);
    endtask

    task automatic t_pid_side_effect;
        // R6
        set_pid(8'h55);
        read_check("R6", 2'd2, 8'd3);
        check("R6", "pid after read", 32'(pid_q), 32'h12);
        do_op(2'd2, 8'd4, 32'd0, 1'b1, 8'h99);
        check("R6", "read beats write", 32'(pid_q), 32'(m_pid[4]));
        set_pid(8'h3C);
        check("R6", "plain load", 32'(pid_q), 32'h3C);
    endtask

    task automatic t_index_mask;
        // R1
        do_op(2'd1, 8'hC9, 32'h7777_7100, 1'b0, 8'd0);
        read_check("R1", 2'd3, 8'h09);
        check("R1", "aliased entry", rd_data, 32'h7777_7100);
    endtask

    task automatic t_search;
        // R8, R9, R10
        set_pid(8'h21);
        do_op(2'd0, 8'd10, 32'h4000_8140, 1'b0, 8'd0);
        do_op(2'd1, 8'd10, 32'h0AAA_A15A, 1'b0, 8'd0);
        set_pid(8'h00);
        do_op(2'd0, 8'd11, 32'h4000_8440, 1'b0, 8'd0);
        do_op(2'd1, 8'd11, 32'h0BBB_B2C3, 1'b0, 8'd0);
        set_pid(8'h21);
        do_op(2'd0, 8'd12, 32'h5000_0040, 1'b0, 8'd0);
        do_op(2'd0, 8'd12, 32'h5000_0000, 1'b0, 8'd0);
        search_check("R9", 32'h4000_8456, 8'h21);
        check("R9", "lowest wins", 32'(srch_index), 32'd10);
        search_check("R8", 32'h4000_8456, 8'h33);
        check("R8", "global entry", 32'(srch_index), 32'd11);
        search_check("R8", 32'h4000_BFFC, 8'h21);
        search_check("R8", 32'h4000_C000, 8'h21);
        check("R8", "beyond page", 32'(srch_hit), 32'd0);
        search_check("R8", 32'h4000_9000, 8'h44);
        search_check("R10", 32'h5000_0010, 8'h21);
        check("R10", "invalid miss", 32'(srch_hit), 32'd0);
        search_check("R8", 32'h1237_FFF0, 8'h12);
        search_check("R8", 32'h1238_0000, 8'h12);
        @(negedge clk);
        check("R10", "done drops", 32'(srch_done), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_page[i] = '0; m_size[i] = 3'd1; m_val[i] = 1'b0; m_pid[i] = '0;
            m_rpnw[i] = '0; m_attr[i] = '0; m_ex[i] = 1'b0; m_wr[i] = 1'b0; m_rd[i] = 1'b0;
        end
        m_cur_pid = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hi_words();
        t_lo_words();
        t_pid_side_effect();
        t_index_mask();
        t_search();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule